// File: doc/BRIEF.md
# DMA Transfer Descriptor Configuration Checker

This block checks a DMA channel's transfer descriptor and the arbitration priority settings for inconsistent values. It reports each problem at the point in the channel's life where it matters. Activation-time checks cover operand sizes, alignment, the minor byte count and priority uniqueness. The scatter/gather address is checked when the major loop completes. The link-bit consistency is checked when a minor loop completes.

The block has three event strobes: channel activation, minor loop completion and major loop completion. On each clock edge where at least one strobe is high, the block evaluates every check that belongs to the strobed events. It then registers a single error flag and a cause code. The outputs hold until the next event. The block does not move data, fetch descriptors or perform arbitration. It only judges the settings presented on its inputs.

Top module: `descCfgChecker`

## Requirements
- R1: While reset is asserted and after it is released, errFlag is 0 and errCause is 0 until the first event strobe is seen.
- R2: Size codes decode as 0→1 byte, 1→2, 2→4, 3→8 and 4→32. Codes 5, 6 and 7 are invalid. An invalid source code reports cause 1 at activation, and an invalid destination code reports cause 2 at activation.
- R3: At activation, cause 1 is reported if the source address or the source offset is not a multiple of the source operand size.
- R4: At activation, cause 2 is reported if the destination address or the destination offset is not a multiple of the destination operand size.
- R5: At activation, cause 3 is reported if the minor byte count is not a multiple of both operand sizes.
- R6: At activation with chanRoundRobin=0, cause 4 is reported if two channels of one group carry the same priority. Channel g,c sits at chanPri bits [(g*CH_PER_GROUP+c)*CH_PRI_W +: CH_PRI_W]. With chanRoundRobin=1, duplicates have no effect.
- R7: At activation with groupRoundRobin=0, cause 5 is reported if two groups carry the same priority. Group g sits at groupPri bits [g*GRP_PRI_W +: GRP_PRI_W]. With groupRoundRobin=1, duplicates have no effect.
- R8: At major loop completion with sgEnable=1, cause 6 is reported if sgAddr is not 32-byte aligned. This check never fires at activation, and it does not fire with sgEnable=0.
- R9: At minor loop completion with minorLinkEnable=1, cause 7 is reported if curIterLinkBit differs from begIterLinkBit. This check never fires at activation.
- R10: When several checks fail at one event, the lowest cause number is reported.
- R11: errFlag and errCause change only on the clock edge after a strobe, and they hold otherwise. An event with no failing check sets both to 0. errFlag is 1 exactly when errCause is nonzero.
- R12: Strobes raised in the same cycle are judged together, using the union of their checks and the precedence of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| activateStb | input | 1 | Channel activation event |
| minorDoneStb | input | 1 | Minor loop completion event |
| majorDoneStb | input | 1 | Major loop completion event |
| srcAddr | input | ADDR_W | Source start address |
| srcOff | input | OFF_W | Signed source offset |
| srcSizeCode | input | 3 | Source operand size code |
| dstAddr | input | ADDR_W | Destination start address |
| dstOff | input | OFF_W | Signed destination offset |
| dstSizeCode | input | 3 | Destination operand size code |
| minorBytes | input | BCNT_W | Minor loop byte count |
| sgEnable | input | 1 | Scatter/gather enabled at completion |
| sgAddr | input | ADDR_W | Next-descriptor address |
| minorLinkEnable | input | 1 | Minor loop channel linking enabled |
| curIterLinkBit | input | 1 | Link-enable bit of the current iteration field |
| begIterLinkBit | input | 1 | Link-enable bit of the beginning iteration field |
| chanRoundRobin | input | 1 | 1 = round-robin within groups |
| groupRoundRobin | input | 1 | 1 = round-robin among groups |
| chanPri | input | NUM_GROUPS*CH_PER_GROUP*CH_PRI_W | Channel priorities |
| groupPri | input | NUM_GROUPS*GRP_PRI_W | Group priorities |
| errFlag | output | 1 | Error seen at the last event |
| errCause | output | 3 | Cause code of the last event, 0 = none |

## Verification
The bench builds the block with two groups of four channels, a 16-bit address, a 12-bit offset and a 10-bit byte count. With these values, group priority is a single bit. The random phase therefore hits both unique and duplicate group settings often. Channel priorities are two bits per channel, so duplicates also arise frequently, alongside unique permutations. The narrower widths also let misaligned and 32-byte-boundary cases come up at a useful rate.

// File: rtl/descChkPkg.sv
package descChkPkg;

  typedef enum logic [2:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_SRC_ALIGN = 3'd1,
    CAUSE_DST_ALIGN = 3'd2,
    CAUSE_BYTE_CNT  = 3'd3,
    CAUSE_CHAN_PRI  = 3'd4,
    CAUSE_GROUP_PRI = 3'd5,
    CAUSE_SG_ALIGN  = 3'd6,
    CAUSE_LINK      = 3'd7
  } causeT;

  typedef struct packed {
    logic evalActivation;
    logic evalScatter;
    logic evalLink;
    logic capture;
  } evalStrobesT;

  localparam int SG_ALIGN_LOG = 5;

  // log2 of operand size; valid flag in the MSB of the result
  function automatic logic [3:0] decodeSize(input logic [2:0] code);
    case (code)
      3'd0: decodeSize = 4'b1_000;
      3'd1: decodeSize = 4'b1_001;
      3'd2: decodeSize = 4'b1_010;
      3'd3: decodeSize = 4'b1_011;
      3'd4: decodeSize = 4'b1_101;
      default: decodeSize = 4'b0_000;
    endcase
  endfunction

endpackage

// File: rtl/descChkAlign.sv
module descChkAlign
  import descChkPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int BCNT_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [OFF_W-1:0]  off,
  input  logic [2:0]        sizeCode,
  input  logic [BCNT_W-1:0] byteCount,
  output logic              sizeBad,
  output logic              misaligned,
  output logic              countBad
);
  logic [3:0]        decoded;
  logic [2:0]        sizeLog;
  logic [ADDR_W-1:0] addrMask;
  logic [OFF_W-1:0]  offMask;
  logic [BCNT_W-1:0] cntMask;

  always_comb begin
    decoded    = decodeSize(sizeCode);
    sizeBad    = !decoded[3];
    sizeLog    = decoded[2:0];
    addrMask   = ~({ADDR_W{1'b1}} << sizeLog);
    offMask    = ~({OFF_W{1'b1}} << sizeLog);
    cntMask    = ~({BCNT_W{1'b1}} << sizeLog);
    misaligned = sizeBad || (|(addr & addrMask)) || (|(off & offMask));
    countBad   = |(byteCount & cntMask);
  end
endmodule

// File: rtl/descChkUnique.sv
module descChkUnique #(
  parameter int COUNT = 4,
  parameter int WIDTH = 2
) (
  input  logic [COUNT*WIDTH-1:0] values,
  output logic                   duplicate
);
  localparam int PAIR_SLOTS = COUNT * COUNT;
  logic [PAIR_SLOTS-1:0] pairHit;

  for (genvar i = 0; i < COUNT; i++) begin : gRow
    for (genvar j = 0; j < COUNT; j++) begin : gCol
      if (j > i) begin : gCmp
        assign pairHit[i*COUNT+j] =
          (values[i*WIDTH +: WIDTH] == values[j*WIDTH +: WIDTH]);
      end else begin : gNone
        assign pairHit[i*COUNT+j] = 1'b0;
      end
    end
  end

  assign duplicate = |pairHit;
endmodule

// File: rtl/descChkCtrl.sv
module descChkCtrl
  import descChkPkg::*;
(
  input  logic        activateStb,
  input  logic        minorDoneStb,
  input  logic        majorDoneStb,
  input  logic        sgEnable,
  input  logic        minorLinkEnable,
  output evalStrobesT strobes
);
  always_comb begin
    strobes.evalActivation = activateStb;
    strobes.evalScatter    = majorDoneStb && sgEnable;
    strobes.evalLink       = minorDoneStb && minorLinkEnable;
    strobes.capture        = activateStb || minorDoneStb || majorDoneStb;
  end
endmodule

// File: rtl/descChkDatapath.sv
module descChkDatapath
  import descChkPkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int OFF_W        = 16,
  parameter int BCNT_W       = 16,
  parameter int NUM_GROUPS   = 4,
  parameter int CH_PER_GROUP = 4,
  parameter int CH_PRI_W     = 2,
  parameter int GRP_PRI_W    = 2
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  evalStrobesT                            strobes,
  input  logic [ADDR_W-1:0]                      srcAddr,
  input  logic [OFF_W-1:0]                       srcOff,
  input  logic [2:0]                             srcSizeCode,
  input  logic [ADDR_W-1:0]                      dstAddr,
  input  logic [OFF_W-1:0]                       dstOff,
  input  logic [2:0]                             dstSizeCode,
  input  logic [BCNT_W-1:0]                      minorBytes,
  input  logic [ADDR_W-1:0]                      sgAddr,
  input  logic                                   curIterLinkBit,
  input  logic                                   begIterLinkBit,
  input  logic                                   chanRoundRobin,
  input  logic                                   groupRoundRobin,
  input  logic [NUM_GROUPS*CH_PER_GROUP*CH_PRI_W-1:0] chanPri,
  input  logic [NUM_GROUPS*GRP_PRI_W-1:0]        groupPri,
  output logic                                   errFlag,
  output causeT                                  errCause
);
  localparam int GROUP_BITS = CH_PER_GROUP * CH_PRI_W;

  logic srcSizeBad, srcMis, srcCntBad;
  logic dstSizeBad, dstMis, dstCntBad;
  logic [NUM_GROUPS-1:0] groupHasDup;
  logic groupsDup;
  logic sgMis, linkMismatch;
  logic chanFail, groupFail;
  causeT nextCause;

  descChkAlign #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BCNT_W(BCNT_W)) i_srcAlign (
    .addr(srcAddr), .off(srcOff), .sizeCode(srcSizeCode), .byteCount(minorBytes),
    .sizeBad(srcSizeBad), .misaligned(srcMis), .countBad(srcCntBad)
  );

  descChkAlign #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BCNT_W(BCNT_W)) i_dstAlign (
    .addr(dstAddr), .off(dstOff), .sizeCode(dstSizeCode), .byteCount(minorBytes),
    .sizeBad(dstSizeBad), .misaligned(dstMis), .countBad(dstCntBad)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gChanUnique
    descChkUnique #(.COUNT(CH_PER_GROUP), .WIDTH(CH_PRI_W)) i_chanUnique (
      .values(chanPri[g*GROUP_BITS +: GROUP_BITS]),
      .duplicate(groupHasDup[g])
    );
  end

  descChkUnique #(.COUNT(NUM_GROUPS), .WIDTH(GRP_PRI_W)) i_groupUnique (
    .values(groupPri),
    .duplicate(groupsDup)
  );

  assign sgMis        = |(sgAddr & ~({ADDR_W{1'b1}} << SG_ALIGN_LOG));
  assign linkMismatch = curIterLinkBit != begIterLinkBit;
  assign chanFail     = !chanRoundRobin && (|groupHasDup);
  assign groupFail    = !groupRoundRobin && groupsDup;

  // later assignments win: lowest cause code takes precedence
  always_comb begin
    nextCause = CAUSE_NONE;
    if (strobes.evalLink && linkMismatch) nextCause = CAUSE_LINK;
    if (strobes.evalScatter && sgMis)     nextCause = CAUSE_SG_ALIGN;
    if (strobes.evalActivation) begin
      if (groupFail)                     nextCause = CAUSE_GROUP_PRI;
      if (chanFail)                      nextCause = CAUSE_CHAN_PRI;
      if (!srcSizeBad && !dstSizeBad && (srcCntBad || dstCntBad))
                                         nextCause = CAUSE_BYTE_CNT;
      if (dstMis || dstSizeBad)          nextCause = CAUSE_DST_ALIGN;
      if (srcMis || srcSizeBad)          nextCause = CAUSE_SRC_ALIGN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCause <= CAUSE_NONE;
      errFlag  <= 1'b0;
    end else if (strobes.capture) begin
      errCause <= nextCause;
      errFlag  <= (nextCause != CAUSE_NONE);
    end
  end
endmodule

// File: rtl/descCfgChecker.sv
module descCfgChecker
  import descChkPkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int OFF_W        = 16,
  parameter int BCNT_W       = 16,
  parameter int NUM_GROUPS   = 4,
  parameter int CH_PER_GROUP = 4,
  parameter int CH_PRI_W     = (CH_PER_GROUP > 1) ? $clog2(CH_PER_GROUP) : 1,
  parameter int GRP_PRI_W    = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic                                        activateStb,
  input  logic                                        minorDoneStb,
  input  logic                                        majorDoneStb,
  input  logic [ADDR_W-1:0]                           srcAddr,
  input  logic [OFF_W-1:0]                            srcOff,
  input  logic [2:0]                                  srcSizeCode,
  input  logic [ADDR_W-1:0]                           dstAddr,
  input  logic [OFF_W-1:0]                            dstOff,
  input  logic [2:0]                                  dstSizeCode,
  input  logic [BCNT_W-1:0]                           minorBytes,
  input  logic                                        sgEnable,
  input  logic [ADDR_W-1:0]                           sgAddr,
  input  logic                                        minorLinkEnable,
  input  logic                                        curIterLinkBit,
  input  logic                                        begIterLinkBit,
  input  logic                                        chanRoundRobin,
  input  logic                                        groupRoundRobin,
  input  logic [NUM_GROUPS*CH_PER_GROUP*CH_PRI_W-1:0] chanPri,
  input  logic [NUM_GROUPS*GRP_PRI_W-1:0]             groupPri,
  output logic                                        errFlag,
  output logic [2:0]                                  errCause
);
  evalStrobesT strobes;
  causeT       causeQ;

  descChkCtrl i_ctrl (
    .activateStb(activateStb), .minorDoneStb(minorDoneStb), .majorDoneStb(majorDoneStb),
    .sgEnable(sgEnable), .minorLinkEnable(minorLinkEnable), .strobes(strobes)
  );

  descChkDatapath #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BCNT_W(BCNT_W), .NUM_GROUPS(NUM_GROUPS),
    .CH_PER_GROUP(CH_PER_GROUP), .CH_PRI_W(CH_PRI_W), .GRP_PRI_W(GRP_PRI_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .srcAddr(srcAddr), .srcOff(srcOff), .srcSizeCode(srcSizeCode),
    .dstAddr(dstAddr), .dstOff(dstOff), .dstSizeCode(dstSizeCode),
    .minorBytes(minorBytes), .sgAddr(sgAddr),
    .curIterLinkBit(curIterLinkBit), .begIterLinkBit(begIterLinkBit),
    .chanRoundRobin(chanRoundRobin), .groupRoundRobin(groupRoundRobin),
    .chanPri(chanPri), .groupPri(groupPri),
    .errFlag(errFlag), .errCause(causeQ)
  );

  assign errCause = causeQ;
endmodule

// File: rtl/descCfgCheckerProps.sv
module descCfgCheckerProps
  import descChkPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              activateStb,
  input logic              minorDoneStb,
  input logic              majorDoneStb,
  input logic [ADDR_W-1:0] srcAddr,
  input logic [2:0]        srcSizeCode,
  input logic              sgEnable,
  input logic [ADDR_W-1:0] sgAddr,
  input logic              minorLinkEnable,
  input logic              curIterLinkBit,
  input logic              begIterLinkBit,
  input logic              errFlag,
  input logic [2:0]        errCause
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (!errFlag && errCause == 3'd0));

  assert_hold_between_events_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(activateStb || minorDoneStb || majorDoneStb) |=> ($stable(errCause) && $stable(errFlag)));

  assert_flag_tracks_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    errFlag == (errCause != 3'd0));

  assert_src_half_misaligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    (activateStb && srcSizeCode == 3'd1 && srcAddr[0]) |=> errCause == CAUSE_SRC_ALIGN);

  assert_sg_at_major_R8: assert property (@(posedge clk) disable iff (!rstN)
    (majorDoneStb && !activateStb && !minorDoneStb && sgEnable && sgAddr[4:0] != 5'd0)
      |=> errCause == CAUSE_SG_ALIGN);

  assert_link_at_minor_R9: assert property (@(posedge clk) disable iff (!rstN)
    (minorDoneStb && !activateStb && !majorDoneStb && minorLinkEnable &&
     curIterLinkBit != begIterLinkBit) |=> errCause == CAUSE_LINK);

  assert_sg_off_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    (majorDoneStb && !activateStb && !minorDoneStb && !sgEnable) |=> errCause == CAUSE_NONE);
endmodule

bind descCfgChecker descCfgCheckerProps #(.ADDR_W(ADDR_W)) i_props (
  .clk(clk), .rstN(rstN), .activateStb(activateStb), .minorDoneStb(minorDoneStb),
  .majorDoneStb(majorDoneStb), .srcAddr(srcAddr), .srcSizeCode(srcSizeCode),
  .sgEnable(sgEnable), .sgAddr(sgAddr), .minorLinkEnable(minorLinkEnable),
  .curIterLinkBit(curIterLinkBit), .begIterLinkBit(begIterLinkBit),
  .errFlag(errFlag), .errCause(errCause)
);

// File: tb/test_descCfgChecker.sv
module test_descCfgChecker;
  localparam int AW = 16, OW = 12, BW = 10, NG = 2, NC = 4, CPW = 2, GPW = 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic activateStb = 0, minorDoneStb = 0, majorDoneStb = 0;
  logic [AW-1:0] srcAddr, dstAddr, sgAddr;
  logic [OW-1:0] srcOff, dstOff;
  logic [2:0] srcSizeCode, dstSizeCode;
  logic [BW-1:0] minorBytes;
  logic sgEnable, minorLinkEnable, curIterLinkBit, begIterLinkBit;
  logic chanRoundRobin, groupRoundRobin;
  logic [NG*NC*CPW-1:0] chanPri;
  logic [NG*GPW-1:0] groupPri;
  logic errFlag;
  logic [2:0] errCause;

  int checks = 0, failures = 0, expCause = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  descCfgChecker #(.ADDR_W(AW), .OFF_W(OW), .BCNT_W(BW), .NUM_GROUPS(NG), .CH_PER_GROUP(NC))
  i_descCfgChecker (.*);

  function automatic int sizeOf(input logic [2:0] c);
    case (c)
      3'd0: return 1; 3'd1: return 2; 3'd2: return 4; 3'd3: return 8; 3'd4: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic int modelCause(input bit act, input bit mi, input bit ma);
    int sb = sizeOf(srcSizeCode);
    int db = sizeOf(dstSizeCode);
    if (act) begin
      if (sb == 0 || int'(srcAddr) % sb != 0 || int'(srcOff) % sb != 0) return 1;
      if (db == 0 || int'(dstAddr) % db != 0 || int'(dstOff) % db != 0) return 2;
      if (int'(minorBytes) % sb != 0 || int'(minorBytes) % db != 0) return 3;
      if (!chanRoundRobin)
        for (int g = 0; g < NG; g++)
          for (int a = 0; a < NC; a++)
            for (int b = a + 1; b < NC; b++)
              if (chanPri[(g*NC+a)*CPW +: CPW] == chanPri[(g*NC+b)*CPW +: CPW]) return 4;
      if (!groupRoundRobin)
        for (int a = 0; a < NG; a++)
          for (int b = a + 1; b < NG; b++)
            if (groupPri[a*GPW +: GPW] == groupPri[b*GPW +: GPW]) return 5;
    end
    if (ma && sgEnable && int'(sgAddr) % 32 != 0) return 6;
    if (mi && minorLinkEnable && curIterLinkBit != begIterLinkBit) return 7;
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) expCause = 0;
    else if (activateStb || minorDoneStb || majorDoneStb)
      expCause = modelCause(activateStb, minorDoneStb, majorDoneStb);
  end

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(errCause) != exp || errFlag != (exp != 0)) begin
      failures++;
      $display("FAIL %s: errCause=%0d errFlag=%0d expected cause=%0d", req, errCause, errFlag, exp);
    end
  endtask

  // every-cycle comparison against the reference model (R11 timing)
  always @(negedge clk) if (rstN && !done) check("R11 model", expCause);

  task automatic setBase();
    srcAddr = 16'h0100; dstAddr = 16'h0200; srcOff = 12'd4; dstOff = 12'd4;
    srcSizeCode = 3'd2; dstSizeCode = 3'd2; minorBytes = 10'd16;
    sgEnable = 0; sgAddr = 16'h0400; minorLinkEnable = 0;
    curIterLinkBit = 0; begIterLinkBit = 0;
    chanRoundRobin = 0; groupRoundRobin = 0;
    for (int g = 0; g < NG; g++)
      for (int c = 0; c < NC; c++) chanPri[(g*NC+c)*CPW +: CPW] = CPW'(c);
    groupPri = 2'b10;
  endtask

  task automatic pulse(input bit a, input bit mi, input bit ma);
    @(negedge clk);
    activateStb = a; minorDoneStb = mi; majorDoneStb = ma;
    @(negedge clk);
    activateStb = 0; minorDoneStb = 0; majorDoneStb = 0;
  endtask

  task automatic actExpect(input string req, input int exp);
    pulse(1, 0, 0); check(req, exp); setBase();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    setBase();
    repeat (3) @(negedge clk);
    check("R1 in reset", 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check("R1 after release", 0);

    actExpect("R11 clean activation", 0);
    srcAddr = 16'h0102;               actExpect("R3 src addr", 1);
    srcOff = 12'hFFE;                 actExpect("R3 src offset", 1);
    srcOff = 12'hFFC;                 actExpect("R3 negative aligned offset", 0);
    dstOff = 12'd6;                   actExpect("R4 dst offset", 2);
    dstAddr = 16'h0201; dstSizeCode = 0; actExpect("R4 byte size any addr", 0);
    srcSizeCode = 3'd5;               actExpect("R2 invalid src code", 1);
    dstSizeCode = 3'd7;               actExpect("R2 invalid dst code", 2);
    srcSizeCode = 3'd4; srcAddr = 16'h0110; srcOff = 12'd32; minorBytes = 10'd32;
                                      actExpect("R2 32-byte size", 1);
    srcSizeCode = 3'd4; srcAddr = 16'h0120; srcOff = 12'd32; minorBytes = 10'd64;
                                      actExpect("R2 32-byte aligned", 0);
    srcSizeCode = 3'd3; srcOff = 12'd8; minorBytes = 10'd12; actExpect("R5 byte count", 3);
    dstSizeCode = 3'd1; minorBytes = 10'd6; srcSizeCode = 3'd0; srcOff = 12'd1;
                                      actExpect("R5 multiple of both", 0);
    chanPri[(NC+3)*CPW +: CPW] = 2'd0; actExpect("R6 chan dup", 4);
    chanPri[(NC+3)*CPW +: CPW] = 2'd0; chanRoundRobin = 1; actExpect("R6 ignored in RR", 0);
    groupPri = 2'b11;                 actExpect("R7 group dup", 5);
    groupPri = 2'b00; groupRoundRobin = 1; actExpect("R7 ignored in RR", 0);

    sgEnable = 1; sgAddr = 16'h0410;  pulse(1, 0, 0); check("R8 not at activation", 0);
    pulse(0, 0, 1);                   check("R8 at major", 6);
    sgAddr = 16'h0420; pulse(0, 0, 1); check("R8 aligned", 0);
    sgEnable = 0; sgAddr = 16'h0411;  pulse(0, 0, 1); check("R8 disabled", 0);
    setBase();
    minorLinkEnable = 1; curIterLinkBit = 1; pulse(1, 0, 0); check("R9 not at activation", 0);
    pulse(0, 1, 0);                   check("R9 at minor", 7);
    minorLinkEnable = 0; pulse(0, 1, 0); check("R9 disabled", 0);
    setBase();

    srcAddr = 16'h0101; dstOff = 12'd1; chanPri[0 +: CPW] = 2'd1; pulse(1, 0, 0);
    check("R10 precedence src", 1);
    srcAddr = 16'h0100; pulse(1, 0, 0); check("R10 precedence dst", 2);
    setBase();
    minorLinkEnable = 1; begIterLinkBit = 1; pulse(1, 1, 0); check("R12 act+minor link", 7);
    minorBytes = 10'd6; pulse(1, 1, 0); check("R12 byte count over link", 3);
    sgEnable = 1; sgAddr = 16'h0404; minorBytes = 10'd16; pulse(0, 1, 1);
    check("R12 sg over link", 6);
    srcAddr = 16'h0001; repeat (4) @(negedge clk); check("R11 hold", 6);
    setBase();

    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      srcAddr = AW'($urandom); dstAddr = AW'($urandom); sgAddr = AW'($urandom);
      srcOff = OW'($urandom); dstOff = OW'($urandom); minorBytes = BW'($urandom);
      if ($urandom_range(1, 0) == 1) begin
        srcAddr[4:0] = 0; dstAddr[4:0] = 0; srcOff[4:0] = 0; dstOff[4:0] = 0; minorBytes[4:0] = 0;
      end
      if ($urandom_range(1, 0) == 1) sgAddr[4:0] = 0;
      srcSizeCode = 3'($urandom_range(5, 0)); dstSizeCode = 3'($urandom_range(5, 0));
      chanPri = (NG*NC*CPW)'($urandom);
      if ($urandom_range(1, 0) == 1) chanPri = 16'b11_10_01_00_00_01_10_11;
      groupPri = 2'($urandom);
      chanRoundRobin = 1'($urandom); groupRoundRobin = 1'($urandom);
      sgEnable = 1'($urandom); minorLinkEnable = 1'($urandom);
      curIterLinkBit = 1'($urandom); begIterLinkBit = 1'($urandom);
      activateStb = ($urandom_range(2, 0) == 0);
      minorDoneStb = ($urandom_range(2, 0) == 0);
      majorDoneStb = ($urandom_range(2, 0) == 0);
    end
    @(negedge clk);
    activateStb = 0; minorDoneStb = 0; majorDoneStb = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule